// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is the control/status register of a real-time clock on a 4-bit processor bus. A write to the control address stores four control bits. Those bits halt the timekeeping counters, halt and reset the interrupt interval timer, place the clock in test mode, and choose which of two register banks the rest of the bus decode uses. A read of the control address returns two sticky status flags. The data-changed flag tells software that the time counters advanced. The interrupt flag tells a polling routine that this clock raised the interrupt.

The block receives two pulses from outside: the clock-setting tick that advances the time counters, and the timeout of the interrupt interval timer. It drives an active-low interrupt line. The time counters, the oscillator and the interval decoding sit outside the block. The read strobe is registered on the system clock. While the registered strobe is high, both flags are frozen. One cycle after the registered strobe falls, the flags clear. A timer timeout that arrives inside a read is held back and posted once the read completes. A clock-setting tick that arrives inside a read is dropped, because time data read on either side of the status read is unaffected by it.

Top module: `rtcc_status_ctl`

## Requirements
- R1: While reset is asserted and just after it, all four control bits are 1 (clk_halt, tmr_clear, test_mode and bank_int high), both flags are 0 (rd_data = 0) and irq_n is high.
- R2: A write with wr_stb high and addr equal to the control address (0) stores wr_data at the next clock edge. Bit 3 drives test_mode, bit 2 drives clk_halt, bit 1 drives bank_int (1 = interrupt register bank) and bit 0 drives tmr_clear. A write to any other address leaves these outputs unchanged.
- R3: rd_data is {data-changed flag, 0, 0, interrupt flag}, with the data-changed flag on bit 3 and the interrupt flag on bit 0.
- R4: A set_tick pulse outside a control read sets the data-changed flag. Writes and reads of other addresses do not clear it.
- R5: A tmr_done pulse outside a control read sets the interrupt flag. irq_n is the inverse of that flag whenever the oscillator route of R11 is inactive.
- R6: A control read (rd_stb high with addr 0) is registered at each edge. At the edge after the registered strobe falls, both flags clear, and irq_n returns high.
- R7: While the registered read strobe is high, neither flag changes.
- R8: A tmr_done pulse during a control read is recorded. The interrupt flag sets, and irq_n falls, at the clear edge that ends the read.
- R9: A set_tick pulse during a control read is discarded and never sets the data-changed flag.
- R10: An event that arrives in the clear cycle itself sets its flag, so setting wins over clearing.
- R11: When test_mode is 1 and int_reg_zero is 1, irq_n follows osc_in.
- R12: After a write of 0 to the control address, clk_halt, tmr_clear, test_mode and bank_int are all 0 (normal running, clock-setting bank).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus register address |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wr_data | input | 4 | Write data |
| set_tick | input | 1 | Clock-setting pulse, one cycle |
| tmr_done | input | 1 | Interrupt timer timeout pulse, one cycle |
| osc_in | input | 1 | Oscillator signal for test routing |
| int_reg_zero | input | 1 | Interrupt interval register holds zero |
| rd_data | output | 4 | Status read value |
| irq_n | output | 1 | Interrupt output, active low |
| clk_halt | output | 1 | Halts the time counters |
| tmr_clear | output | 1 | Holds the interrupt timer reset and halted |
| test_mode | output | 1 | Test mode active |
| bank_int | output | 1 | Register bank select, 1 = interrupt register |

## Verification
The in-RTL assertions check on every cycle that the flags stay frozen while a read is registered, that an event outside a read sets its flag, that the tail of a read clears a flag when no event is pending, that a timeout inside a read is held pending, and that control bits change only on a write. Some behaviours only show up across a sequence of operations: the timeout deferred to the end of a read, the tick dropped inside a read, an event that lands exactly in the clear cycle, flags that survive writes and other-address reads, and the oscillator route in test mode. The bench's directed and random scenarios cover these against a bench-side model.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int BUS_W = 4;

    typedef struct packed {
        logic test;      // bit 3
        logic clk_stop;  // bit 2
        logic bank;      // bit 1
        logic int_stop;  // bit 0
    } rtcc_ctl_t;

    typedef struct packed {
        logic active;    // registered read strobe high
        logic tail;      // registered strobe just fell
    } rd_phase_t;

    localparam rtcc_ctl_t CTL_RESET = '{test: 1'b1, clk_stop: 1'b1, bank: 1'b1, int_stop: 1'b1};

    function automatic logic [BUS_W-1:0] pack_status(input logic dchg, input logic intf);
        return {dchg, 2'b00, intf};
    endfunction
endpackage

// File: rtl/rtcc_ctl_store.sv
module rtcc_ctl_store
    import rtcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output rtcc_ctl_t        ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= CTL_RESET;
        else if (wr_en)
            ctl <= rtcc_ctl_t'(wr_data);
    end

    // R2: control bits move only on a control write
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl));
endmodule

// File: rtl/rtcc_rd_track.sv
module rtcc_rd_track
    import rtcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    output rd_phase_t ph
);
    logic rd_q;
    logic rd_q_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            rd_q_d <= 1'b0;
        end else begin
            rd_q   <= rd_en;
            rd_q_d <= rd_q;
        end
    end

    assign ph.active = rd_q;
    assign ph.tail   = rd_q_d & ~rd_q;

    // R6: a read that ends produces a tail cycle
    assert_tail_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        (ph.active && !rd_en) |=> ph.tail);
endmodule

// File: rtl/rtcc_sticky_flag.sv
module rtcc_sticky_flag #(
    parameter bit DEFER = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic event_in,
    input  logic rd_active,
    input  logic rd_tail,
    output logic flag
);
    logic pend;

    generate
        if (DEFER) begin : g_defer
            always_ff @(posedge clk) begin
                if (rst)
                    pend <= 1'b0;
                else if (rd_active && event_in)
                    pend <= 1'b1;
                else if (rd_tail)
                    pend <= 1'b0;
            end
            // R8: timeout inside a read is kept pending
            assert_defer_record_R8: assert property (@(posedge clk) disable iff (rst)
                (rd_active && event_in) |=> pend);
        end else begin : g_drop
            assign pend = 1'b0;
            // R9: event inside a read cannot raise a clear flag
            assert_drop_in_read_R9: assert property (@(posedge clk) disable iff (rst)
                (rd_active && !flag) |=> !flag);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (rd_active)
            flag <= flag;
        else if (rd_tail)
            flag <= event_in | pend;
        else
            flag <= flag | event_in;
    end

    // R7: frozen while the registered strobe is high
    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        rd_active |=> $stable(flag));
    // R4 / R5: an event outside a read sets the flag
    assert_event_sets_R4_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_active && event_in) |=> flag);
    // R6: the tail clears a flag when nothing is pending
    assert_tail_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_tail && !event_in && !pend) |=> !flag);
endmodule

// File: rtl/rtcc_status_ctl.sv
module rtcc_status_ctl
    import rtcc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              set_tick,
    input  logic              tmr_done,
    input  logic              osc_in,
    input  logic              int_reg_zero,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq_n,
    output logic              clk_halt,
    output logic              tmr_clear,
    output logic              test_mode,
    output logic              bank_int
);
    localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);

    logic       sel;
    rtcc_ctl_t  ctl;
    rd_phase_t  ph;
    logic       dchg_flag;
    logic       int_flag;
    logic       osc_route;

    assign sel = (addr == CTL_SEL);

    rtcc_ctl_store u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_stb & sel),
        .wr_data (wr_data),
        .ctl     (ctl)
    );

    rtcc_rd_track u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_stb & sel),
        .ph    (ph)
    );

    rtcc_sticky_flag #(.DEFER(1'b0)) u_dchg (
        .clk       (clk),
        .rst       (rst),
        .event_in  (set_tick),
        .rd_active (ph.active),
        .rd_tail   (ph.tail),
        .flag      (dchg_flag)
    );

    rtcc_sticky_flag #(.DEFER(1'b1)) u_int (
        .clk       (clk),
        .rst       (rst),
        .event_in  (tmr_done),
        .rd_active (ph.active),
        .rd_tail   (ph.tail),
        .flag      (int_flag)
    );

    assign osc_route = ctl.test & int_reg_zero;
    assign irq_n     = osc_route ? osc_in : ~int_flag;
    assign rd_data   = pack_status(dchg_flag, int_flag);
    assign clk_halt  = ctl.clk_stop;
    assign tmr_clear = ctl.int_stop;
    assign test_mode = ctl.test;
    assign bank_int  = ctl.bank;
endmodule

// File: tb/rtcc_status_ctl_tb.sv
module rtcc_status_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_stb = 1'b0;
    logic              wr_stb = 1'b0;
    logic [3:0]        wr_data = '0;
    logic              set_tick = 1'b0;
    logic              tmr_done = 1'b0;
    logic              osc_in = 1'b0;
    logic              int_reg_zero = 1'b0;
    logic [3:0]        rd_data;
    logic              irq_n, clk_halt, tmr_clear, test_mode, bank_int;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench model state
    logic [3:0] m_ctl;
    logic m_rdq, m_rdqd, m_dchg, m_int, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcc_status_ctl #(.ADDR_W(ADDR_W), .CTL_ADDR(0)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .set_tick(set_tick), .tmr_done(tmr_done),
        .osc_in(osc_in), .int_reg_zero(int_reg_zero), .rd_data(rd_data),
        .irq_n(irq_n), .clk_halt(clk_halt), .tmr_clear(tmr_clear),
        .test_mode(test_mode), .bank_int(bank_int)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic exp_irq_n();
        return (m_ctl[3] && int_reg_zero) ? osc_in : ~m_int;
    endfunction

    task automatic model_edge();
        logic sel;
        sel = (addr == '0);
        if (rst) begin
            m_ctl = 4'hF; m_rdq = 0; m_rdqd = 0; m_dchg = 0; m_int = 0; m_pend = 0;
        end else begin
            if (wr_stb && sel) m_ctl = wr_data;
            if (m_rdq) begin
                if (tmr_done) m_pend = 1'b1;
            end else if (m_rdqd) begin
                m_dchg = set_tick;
                m_int  = m_pend | tmr_done;
                m_pend = 1'b0;
            end else begin
                m_dchg = m_dchg | set_tick;
                m_int  = m_int | tmr_done;
            end
            m_rdqd = m_rdq;
            m_rdq  = rd_stb && sel;
        end
    endtask

    // one clock: model update at the edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        chk("R3 rd_data", rd_data, {m_dchg, 2'b00, m_int});
        chk("R5 irq_n", {3'b0, irq_n}, {3'b0, exp_irq_n()});
        chk("R2 controls", {test_mode, clk_halt, bank_int, tmr_clear}, m_ctl);
    endtask

    task automatic idle();
        rd_stb = 0; wr_stb = 0; set_tick = 0; tmr_done = 0; addr = '0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1234);
        idle();
        rst = 1;
        step(); step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 controls", {test_mode, clk_halt, bank_int, tmr_clear}, 4'hF);
        chk("R1 flags", rd_data, 4'h0);
        chk("R1 irq_n", {3'b0, irq_n}, 4'h1);

        // R12 write zero
        wr_stb = 1; wr_data = 4'h0; step(); idle(); step();
        chk("R12 normal", {test_mode, clk_halt, bank_int, tmr_clear}, 4'h0);
        // R2 write elsewhere ignored
        wr_stb = 1; addr = 4'h1; wr_data = 4'hF; step(); idle(); step();
        chk("R2 other addr", {test_mode, clk_halt, bank_int, tmr_clear}, 4'h0);
        // R2 field positions
        wr_stb = 1; wr_data = 4'b0110; step(); idle(); step();
        chk("R2 bits", {test_mode, clk_halt, bank_int, tmr_clear}, 4'b0110);
        wr_stb = 1; wr_data = 4'h0; step(); idle(); step();

        // R4 tick sets, survives other reads and writes
        set_tick = 1; step(); idle(); step();
        chk("R4 set", rd_data, 4'b1000);
        addr = 4'h2; rd_stb = 1; step(); step(); step(); idle(); step(); step();
        chk("R4 other read", rd_data, 4'b1000);
        wr_stb = 1; wr_data = 4'h0; step(); idle(); step();
        chk("R4 write", rd_data, 4'b1000);

        // control read with events inside: R7 R8 R9
        rd_stb = 1; step();                       // registered strobe high
        tmr_done = 1; set_tick = 1; step();       // events inside the read
        tmr_done = 0; set_tick = 0; step();
        chk("R7 frozen", rd_data, 4'b1000);
        chk("R8 irq held", {3'b0, irq_n}, 4'h1);
        rd_stb = 0; step();                       // tail cycle now
        chk("R7 frozen tail", rd_data, 4'b1000);
        step();                                   // clear edge
        chk("R9 tick dropped", {3'b0, rd_data[3]}, 4'h0);
        chk("R8 deferred int", {3'b0, rd_data[0]}, 4'h1);
        chk("R8 irq low", {3'b0, irq_n}, 4'h0);

        // R6 clear and R10 tick in the clear cycle
        rd_stb = 1; step(); rd_stb = 0; step();
        chk("R6 before clear", rd_data, 4'b0001);
        set_tick = 1; step(); idle();
        chk("R6 int cleared", {3'b0, rd_data[0]}, 4'h0);
        chk("R6 irq high", {3'b0, irq_n}, 4'h1);
        chk("R10 set wins", {3'b0, rd_data[3]}, 4'h1);

        // R11 oscillator route
        tmr_done = 1; step(); idle();
        wr_stb = 1; wr_data = 4'b1000; step(); idle();
        int_reg_zero = 1; osc_in = 1; step();
        chk("R11 osc high", {3'b0, irq_n}, 4'h1);
        osc_in = 0; step();
        chk("R11 osc low", {3'b0, irq_n}, 4'h0);
        osc_in = 1; step();
        chk("R11 osc high again", {3'b0, irq_n}, 4'h1);
        int_reg_zero = 0; step();
        chk("R5 route off", {3'b0, irq_n}, 4'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 4 == 0) rd_stb = ~rd_stb;
            addr         = ($urandom % 4 == 0) ? ADDR_W'($urandom % 4) : '0;
            wr_stb       = ($urandom % 16 == 0);
            wr_data      = 4'($urandom);
            set_tick     = ($urandom % 5 == 0);
            tmr_done     = ($urandom % 6 == 0);
            osc_in       = 1'($urandom);
            int_reg_zero = ($urandom % 3 == 0);
            rst          = ($urandom % 997 == 0);
            step();
        end
        rst = 0; idle();
        step(); step();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule